// File: doc/BRIEF.md
# Floating-Point Control/Status Register with Rounding-Mode Resolver

This block keeps the single-precision floating-point control and status word for a core. The word is eight live bits: a 3-bit dynamic rounding mode and five sticky exception flags. All bits above them are hard-wired to zero. Software reaches the word through three access views: the whole word, the rounding mode alone, and the flags alone. Each view accepts a read, a swap, a set-bits or a clear-bits operation, and every one of them returns the value held before the access. Retiring arithmetic operations report exception flags, and the block ORs them into the sticky field, merging them with any software write in the same cycle.

The block also takes the rounding-mode field of the issuing instruction and resolves it to the effective mode. It raises an illegal-instruction indication for reserved static codes and for reserved stored modes when the dynamic mode is selected. It also keeps the two-bit floating-point context status. In precise tracking mode, that status moves to dirty on the same clock edge that commits any change to floating-point state.

Top module: `fcsr_unit`

## Requirements
- R1: After reset the rounding mode is 000, all five flags are 0, and the context status equals the FS_RESET parameter (default 01).
- R2: A whole-word access (view code 00) returns the rounding mode in bits 7..5 and the flags in bits 4..0. Every bit from 8 up to XLEN-1 reads as zero.
- R3: A swap (op code 01) returns the old value and then loads the source value. Source bits outside the live bits of the view are ignored.
- R4: The rounding-mode view (code 01) returns the mode in bits 2..0, and the flags view (code 10) returns the flags in bits 4..0, with all other bits zero. A write through either view uses only those low source bits and leaves the other field unchanged. View code 11 returns zero and changes nothing.
- R5: Set-bits (op 10) ORs the masked source into the field, and clear-bits (op 11) clears the masked source bits. When the masked source is zero, neither op writes state or marks the context dirty.
- R6: Flag bits are sticky and stay set until a software write through the whole-word or flags view changes them. The bit order is invalid=4, divide-by-zero=3, overflow=2, underflow=1, inexact=0.
- R7: A reported flag vector is ORed into the flags on the next edge. If software writes the flags in the same cycle, the stored result is the software value ORed with the reported bits.
- R8: An instruction rounding code 000..100 (nearest-even, toward zero, down, up, nearest-max) passes through as the effective mode with no illegal indication. Codes 101 and 110 raise the illegal indication.
- R9: Instruction code 111 selects the stored mode as the effective mode. A stored mode of 101, 110 or 111 then raises the illegal indication.
- R10: With DIRTY_PRECISE=1, the context status becomes 11 (dirty) on the edge that commits a floating-point register write, a software write of the word, or a nonzero flag report.
- R11: A status load request sets the context status to the supplied value. A dirtying event on the same edge takes priority and gives 11.
- R12: A read op (code 00) changes no state and does not alter the context status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| csr_req_i | input | 1 | Software access valid this cycle |
| csr_view_i | input | 2 | 00 whole word, 01 rounding mode, 10 flags, 11 none |
| csr_op_i | input | 2 | 00 read, 01 swap, 10 set bits, 11 clear bits |
| csr_src_i | input | XLEN | Source operand from the integer register |
| csr_rdata_o | output | XLEN | Old value of the selected view, zero-extended |
| flag_valid_i | input | 1 | Datapath exception report valid |
| flag_bits_i | input | 5 | Reported flags (invalid, div-zero, overflow, underflow, inexact) |
| fpr_write_i | input | 1 | A floating-point register is written this cycle |
| instr_rm_i | input | 3 | Rounding field of the issuing instruction |
| eff_rm_o | output | 3 | Resolved rounding mode |
| rm_illegal_o | output | 1 | Reserved rounding combination |
| fs_load_i | input | 1 | Load the context status |
| fs_load_val_i | input | 2 | Value for the status load |
| fs_o | output | 2 | Floating-point context status |

## Verification
The bench builds the block with XLEN=64 and DIRTY_PRECISE=1. A 64-bit source lets the bench drive ones into every reserved position and confirm that reads zero-extend across a wide word. Precise tracking makes the dirty transition observable on every edge, including the case where it competes with a status load. The random phase mixes all views and ops with flag reports, register writes and instruction rounding codes. This covers same-cycle merges of software flag writes with datapath reports, and dynamic resolution against every stored mode, including reserved modes written through the whole-word view.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;

    localparam int unsigned RM_W    = 3;
    localparam int unsigned FLAG_W  = 5;
    localparam int unsigned FIELD_W = RM_W + FLAG_W;

    localparam int unsigned FLAG_INVALID  = 4;
    localparam int unsigned FLAG_DIVZERO  = 3;
    localparam int unsigned FLAG_OVERFLOW = 2;
    localparam int unsigned FLAG_UNDERFL  = 1;
    localparam int unsigned FLAG_INEXACT  = 0;

    typedef enum logic [1:0] {
        VIEW_WORD  = 2'd0,
        VIEW_RMODE = 2'd1,
        VIEW_FLAGS = 2'd2,
        VIEW_NONE  = 2'd3
    } csr_view_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_SWAP  = 2'd1,
        OP_SETB  = 2'd2,
        OP_CLRB  = 2'd3
    } csr_op_e;

    localparam logic [RM_W-1:0] RMODE_NEAR_EVEN = 3'd0;
    localparam logic [RM_W-1:0] RMODE_TO_ZERO   = 3'd1;
    localparam logic [RM_W-1:0] RMODE_DOWN      = 3'd2;
    localparam logic [RM_W-1:0] RMODE_UP        = 3'd3;
    localparam logic [RM_W-1:0] RMODE_NEAR_MAX  = 3'd4;
    localparam logic [RM_W-1:0] RMODE_DYNAMIC   = 3'd7;

    localparam logic [1:0] CTX_OFF     = 2'd0;
    localparam logic [1:0] CTX_INITIAL = 2'd1;
    localparam logic [1:0] CTX_CLEAN   = 2'd2;
    localparam logic [1:0] CTX_DIRTY   = 2'd3;

    typedef struct packed {
        logic [RM_W-1:0]   frm;
        logic [FLAG_W-1:0] fflags;
        logic [1:0]        fs;
    } fcsr_state_t;

endpackage

// File: rtl/fcsr_access.sv
module fcsr_access
    import fcsr_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                 req_i,
    input  logic [1:0]           view_i,
    input  logic [1:0]           op_i,
    input  logic [XLEN-1:0]      src_i,
    input  logic [RM_W-1:0]      frm_i,
    input  logic [FLAG_W-1:0]    fflags_i,
    output logic [XLEN-1:0]      rdata_o,
    output logic                 frm_wr_o,
    output logic [RM_W-1:0]      frm_new_o,
    output logic                 flags_wr_o,
    output logic [FLAG_W-1:0]    flags_new_o
);

    localparam int unsigned PAD_W = XLEN - FIELD_W;

    csr_view_e          view_e;
    csr_op_e            op_e;
    logic [FIELD_W-1:0] old_v;
    logic [FIELD_W-1:0] mask_v;
    logic [FIELD_W-1:0] src_v;
    logic [FIELD_W-1:0] new_v;
    logic               in_view;
    logic               active;
    logic               does_write;
    logic               unused_src_hi;

    assign view_e        = csr_view_e'(view_i);
    assign op_e          = csr_op_e'(op_i);
    assign unused_src_hi = ^src_i[XLEN-1:FIELD_W];

    // Align the selected view to bit 0 and build its live-bit mask.
    always_comb begin
        old_v   = '0;
        mask_v  = '0;
        in_view = 1'b1;
        unique case (view_e)
            VIEW_WORD: begin
                old_v  = {frm_i, fflags_i};
                mask_v = {FIELD_W{1'b1}};
            end
            VIEW_RMODE: begin
                old_v  = {{FLAG_W{1'b0}}, frm_i};
                mask_v = {{FLAG_W{1'b0}}, {RM_W{1'b1}}};
            end
            VIEW_FLAGS: begin
                old_v  = {{RM_W{1'b0}}, fflags_i};
                mask_v = {{RM_W{1'b0}}, {FLAG_W{1'b1}}};
            end
            default: in_view = 1'b0;
        endcase
    end

    assign src_v  = src_i[FIELD_W-1:0] & mask_v;
    assign active = req_i & in_view;

    // Compute the new field value for each operation.
    always_comb begin
        unique case (op_e)
            OP_SWAP: new_v = src_v;
            OP_SETB: new_v = old_v | src_v;
            OP_CLRB: new_v = old_v & ~src_v;
            default: new_v = old_v;
        endcase
    end

    // Swap always writes; set and clear write only with a nonzero mask.
    always_comb begin
        unique case (op_e)
            OP_SWAP:          does_write = active;
            OP_SETB, OP_CLRB: does_write = active & (|src_v);
            default:          does_write = 1'b0;
        endcase
    end

    assign rdata_o = active ? {{PAD_W{1'b0}}, old_v} : '0;

    // Route the new value back to the field(s) the view covers.
    always_comb begin
        frm_wr_o    = 1'b0;
        flags_wr_o  = 1'b0;
        frm_new_o   = frm_i;
        flags_new_o = fflags_i;
        unique case (view_e)
            VIEW_WORD: begin
                frm_wr_o    = does_write;
                flags_wr_o  = does_write;
                frm_new_o   = new_v[FIELD_W-1:FLAG_W];
                flags_new_o = new_v[FLAG_W-1:0];
            end
            VIEW_RMODE: begin
                frm_wr_o  = does_write;
                frm_new_o = new_v[RM_W-1:0];
            end
            VIEW_FLAGS: begin
                flags_wr_o  = does_write;
                flags_new_o = new_v[FLAG_W-1:0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fcsr_rm_resolve.sv
module fcsr_rm_resolve
    import fcsr_pkg::*;
(
    input  logic [RM_W-1:0] instr_rm_i,
    input  logic [RM_W-1:0] frm_i,
    output logic [RM_W-1:0] eff_rm_o,
    output logic            illegal_o
);

    logic use_dyn;
    logic static_bad;
    logic stored_bad;

    assign use_dyn    = (instr_rm_i == RMODE_DYNAMIC);
    // Static codes above nearest-max, excluding the dynamic selector.
    assign static_bad = (instr_rm_i > RMODE_NEAR_MAX) & ~use_dyn;
    // Any stored code above nearest-max is reserved, including 111.
    assign stored_bad = (frm_i > RMODE_NEAR_MAX);

    assign eff_rm_o  = use_dyn ? frm_i : instr_rm_i;
    assign illegal_o = static_bad | (use_dyn & stored_bad);

endmodule

// File: rtl/fcsr_ctx_track.sv
module fcsr_ctx_track
    import fcsr_pkg::*;
#(
    parameter bit DIRTY_PRECISE = 1'b1
) (
    input  logic [1:0] fs_q_i,
    input  logic       modify_i,
    input  logic       load_i,
    input  logic [1:0] load_val_i,
    output logic [1:0] fs_d_o
);

    logic [1:0] loaded;

    assign loaded = load_i ? load_val_i : fs_q_i;

    generate
        if (DIRTY_PRECISE) begin : g_precise
            assign fs_d_o = modify_i ? CTX_DIRTY : loaded;
        end else begin : g_never
            logic unused_modify;
            assign unused_modify = modify_i;
            assign fs_d_o        = loaded;
        end
    endgenerate

endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
    import fcsr_pkg::*;
#(
    parameter int unsigned XLEN          = 32,
    parameter bit          DIRTY_PRECISE = 1'b1,
    parameter logic [1:0]  FS_RESET      = 2'd1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               csr_req_i,
    input  logic [1:0]         csr_view_i,
    input  logic [1:0]         csr_op_i,
    input  logic [XLEN-1:0]    csr_src_i,
    output logic [XLEN-1:0]    csr_rdata_o,
    input  logic               flag_valid_i,
    input  logic [4:0]         flag_bits_i,
    input  logic               fpr_write_i,
    input  logic [2:0]         instr_rm_i,
    output logic [2:0]         eff_rm_o,
    output logic               rm_illegal_o,
    input  logic               fs_load_i,
    input  logic [1:0]         fs_load_val_i,
    output logic [1:0]         fs_o
);

    fcsr_state_t       state_q;
    fcsr_state_t       state_d;
    logic              frm_wr;
    logic [RM_W-1:0]   frm_new;
    logic              flags_wr;
    logic [FLAG_W-1:0] flags_new;
    logic              modify;
    logic [1:0]        fs_next;

    fcsr_access #(
        .XLEN(XLEN)
    ) u_access (
        .req_i      (csr_req_i),
        .view_i     (csr_view_i),
        .op_i       (csr_op_i),
        .src_i      (csr_src_i),
        .frm_i      (state_q.frm),
        .fflags_i   (state_q.fflags),
        .rdata_o    (csr_rdata_o),
        .frm_wr_o   (frm_wr),
        .frm_new_o  (frm_new),
        .flags_wr_o (flags_wr),
        .flags_new_o(flags_new)
    );

    fcsr_rm_resolve u_resolve (
        .instr_rm_i(instr_rm_i),
        .frm_i     (state_q.frm),
        .eff_rm_o  (eff_rm_o),
        .illegal_o (rm_illegal_o)
    );

    assign modify = fpr_write_i | frm_wr | flags_wr | (flag_valid_i & (|flag_bits_i));

    fcsr_ctx_track #(
        .DIRTY_PRECISE(DIRTY_PRECISE)
    ) u_ctx (
        .fs_q_i    (state_q.fs),
        .modify_i  (modify),
        .load_i    (fs_load_i),
        .load_val_i(fs_load_val_i),
        .fs_d_o    (fs_next)
    );

    always_comb begin
        logic [FLAG_W-1:0] flags_base;
        state_d    = state_q;
        flags_base = flags_wr ? flags_new : state_q.fflags;
        if (frm_wr) begin
            state_d.frm = frm_new;
        end
        state_d.fflags = flag_valid_i ? (flags_base | flag_bits_i) : flags_base;
        state_d.fs     = fs_next;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q.frm    <= RMODE_NEAR_EVEN;
            state_q.fflags <= '0;
            state_q.fs     <= FS_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign fs_o = state_q.fs;

endmodule

// File: rtl/fcsr_unit_chk.sv
module fcsr_unit_chk #(
    parameter int unsigned XLEN          = 32,
    parameter bit          DIRTY_PRECISE = 1'b1
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            csr_req_i,
    input logic [1:0]      csr_view_i,
    input logic [1:0]      csr_op_i,
    input logic [XLEN-1:0] csr_rdata_o,
    input logic            flag_valid_i,
    input logic [4:0]      flag_bits_i,
    input logic            fpr_write_i,
    input logic [2:0]      instr_rm_i,
    input logic [2:0]      eff_rm_o,
    input logic            rm_illegal_o,
    input logic            fs_load_i,
    input logic [1:0]      fs_o,
    input logic [2:0]      frm_q,
    input logic [4:0]      fflags_q,
    input logic            flags_sw_wr
);

    p_word_high_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_req_i && csr_view_i == 2'd0) |-> (csr_rdata_o[XLEN-1:8] == '0));

    p_rm_view_zext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_req_i && csr_view_i == 2'd1) |-> (csr_rdata_o[XLEN-1:3] == '0));

    p_flag_view_zext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_req_i && csr_view_i == 2'd2) |-> (csr_rdata_o[XLEN-1:5] == '0));

    p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flags_sw_wr |=> ((fflags_q & $past(fflags_q)) == $past(fflags_q)));

    p_report_merge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_valid_i |=> ((fflags_q & $past(flag_bits_i)) == $past(flag_bits_i)));

    p_static_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_rm_i <= 3'd4) |-> (!rm_illegal_o && eff_rm_o == instr_rm_i));

    p_static_rsvd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_rm_i == 3'd5 || instr_rm_i == 3'd6) |-> rm_illegal_o);

    p_dynamic_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_rm_i == 3'd7) |-> (eff_rm_o == frm_q && rm_illegal_o == (frm_q > 3'd4)));

    p_fpr_dirty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (DIRTY_PRECISE && fpr_write_i) |=> (fs_o == 2'd3));

    p_read_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_req_i && csr_op_i == 2'd0 && !flag_valid_i && !fpr_write_i && !fs_load_i)
        |=> ($stable(fs_o) && $stable(frm_q) && $stable(fflags_q)));

endmodule

bind fcsr_unit fcsr_unit_chk #(
    .XLEN         (XLEN),
    .DIRTY_PRECISE(DIRTY_PRECISE)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csr_req_i   (csr_req_i),
    .csr_view_i  (csr_view_i),
    .csr_op_i    (csr_op_i),
    .csr_rdata_o (csr_rdata_o),
    .flag_valid_i(flag_valid_i),
    .flag_bits_i (flag_bits_i),
    .fpr_write_i (fpr_write_i),
    .instr_rm_i  (instr_rm_i),
    .eff_rm_o    (eff_rm_o),
    .rm_illegal_o(rm_illegal_o),
    .fs_load_i   (fs_load_i),
    .fs_o        (fs_o),
    .frm_q       (state_q.frm),
    .fflags_q    (state_q.fflags),
    .flags_sw_wr (flags_wr)
);

// File: tb/fcsr_unit_tb.sv
module fcsr_unit_tb;

    localparam int unsigned XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_req = 1'b0;
    logic [1:0]      csr_view = '0;
    logic [1:0]      csr_op = '0;
    logic [XLEN-1:0] csr_src = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            flag_valid = 1'b0;
    logic [4:0]      flag_bits = '0;
    logic            fpr_write = 1'b0;
    logic [2:0]      instr_rm = '0;
    logic [2:0]      eff_rm;
    logic            rm_illegal;
    logic            fs_load = 1'b0;
    logic [1:0]      fs_load_val = '0;
    logic [1:0]      fs;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;

    // Bench model of the architectural state.
    logic [2:0] m_rm;
    logic [4:0] m_flags;
    logic [1:0] m_fs;

    always #5 clk = ~clk;

    fcsr_unit #(
        .XLEN         (XLEN),
        .DIRTY_PRECISE(1'b1),
        .FS_RESET     (2'd1)
    ) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .csr_req_i    (csr_req),
        .csr_view_i   (csr_view),
        .csr_op_i     (csr_op),
        .csr_src_i    (csr_src),
        .csr_rdata_o  (csr_rdata),
        .flag_valid_i (flag_valid),
        .flag_bits_i  (flag_bits),
        .fpr_write_i  (fpr_write),
        .instr_rm_i   (instr_rm),
        .eff_rm_o     (eff_rm),
        .rm_illegal_o (rm_illegal),
        .fs_load_i    (fs_load),
        .fs_load_val_i(fs_load_val),
        .fs_o         (fs)
    );

    task automatic check(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] exp_read(logic req, logic [1:0] view, logic [2:0] rm,
                                                 logic [4:0] fl);
        if (!req) return '0;
        case (view)
            2'd0:    return XLEN'({rm, fl});
            2'd1:    return XLEN'(rm);
            2'd2:    return XLEN'(fl);
            default: return '0;
        endcase
    endfunction

    function automatic logic [2:0] exp_eff(logic [2:0] irm, logic [2:0] rm);
        return (irm == 3'd7) ? rm : irm;
    endfunction

    function automatic logic exp_ill(logic [2:0] irm, logic [2:0] rm);
        if (irm == 3'd7) return rm > 3'd4;
        return (irm == 3'd5) || (irm == 3'd6);
    endfunction

    function automatic string req_tag(logic [1:0] view, logic [1:0] op);
        if (op == 2'd1) return "R3";
        if (op != 2'd0) return "R5";
        return (view == 2'd0) ? "R2" : "R4";
    endfunction

    // One cycle: drive at the falling edge, check combinational outputs,
    // advance the model, then check the registered status after the edge.
    task automatic step(logic req, logic [1:0] view, logic [1:0] op, logic [XLEN-1:0] src,
                        logic fv, logic [4:0] fb, logic fw, logic fl, logic [1:0] flv,
                        logic [2:0] irm);
        logic [7:0] old8, mask8, src8, new8;
        logic       in_view, wr, rm_wr, fl_wr, modify;
        @(negedge clk);
        csr_req = req; csr_view = view; csr_op = op; csr_src = src;
        flag_valid = fv; flag_bits = fb; fpr_write = fw;
        fs_load = fl; fs_load_val = flv; instr_rm = irm;
        #1;
        check(req_tag(view, op), "read data", csr_rdata, exp_read(req, view, m_rm, m_flags));
        check(irm == 3'd7 ? "R9" : "R8", "effective mode", XLEN'(eff_rm), XLEN'(exp_eff(irm, m_rm)));
        check(irm == 3'd7 ? "R9" : "R8", "illegal", XLEN'(rm_illegal), XLEN'(exp_ill(irm, m_rm)));

        in_view = req && (view != 2'd3);
        case (view)
            2'd0:    begin old8 = {m_rm, m_flags}; mask8 = 8'hFF; end
            2'd1:    begin old8 = {5'd0, m_rm};    mask8 = 8'h07; end
            2'd2:    begin old8 = {3'd0, m_flags}; mask8 = 8'h1F; end
            default: begin old8 = 8'd0;            mask8 = 8'h00; end
        endcase
        src8 = src[7:0] & mask8;
        case (op)
            2'd1:    new8 = src8;
            2'd2:    new8 = old8 | src8;
            2'd3:    new8 = old8 & ~src8;
            default: new8 = old8;
        endcase
        wr    = in_view && ((op == 2'd1) || (op != 2'd0 && src8 != 8'd0));
        rm_wr = wr && (view == 2'd0 || view == 2'd1);
        fl_wr = wr && (view == 2'd0 || view == 2'd2);
        modify = fw || wr || (fv && fb != 5'd0);
        if (rm_wr) m_rm = (view == 2'd0) ? new8[7:5] : new8[2:0];
        if (fl_wr) m_flags = new8[4:0];
        if (fv) m_flags = m_flags | fb;
        if (modify) m_fs = 2'd3;
        else if (fl) m_fs = flv;

        @(posedge clk);
        #1;
        check(modify ? "R10" : (fl ? "R11" : "R12"), "context status", XLEN'(fs), XLEN'(m_fs));
    endtask

    task automatic idle();
        step(1'b0, 2'd0, 2'd0, '0, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 3'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        m_rm = 3'd0; m_flags = 5'd0; m_fs = 2'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen through the whole-word view and status port.
        #1;
        check("R1", "status after reset", XLEN'(fs), XLEN'(2'd1));
        step(1'b1, 2'd0, 2'd0, '0, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 3'd7);
        check("R1", "word after reset", csr_rdata, '0);

        // R3: swap with every reserved bit set; R2: upper bits read zero.
        step(1'b1, 2'd0, 2'd1, {XLEN{1'b1}}, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 3'd0);
        step(1'b1, 2'd0, 2'd0, '0, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 3'd7);
        check("R2", "reserved bits zero", csr_rdata, XLEN'(8'hFF));

        // R4: rounding view write leaves flags; flags view write leaves mode.
        step(1'b1, 2'd1, 2'd1, 64'hFFFF_FFF9, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 3'd0);
        step(1'b1, 2'd2, 2'd1, 64'hA5A0, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 3'd0);
        step(1'b1, 2'd0, 2'd0, '0, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 3'd0);
        check("R4", "mode and flags kept apart", csr_rdata, XLEN'({3'd1, 5'd0}));
        // R4: view code 11 returns zero.
        step(1'b1, 2'd3, 2'd1, 64'hFF, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 3'd0);
        check("R4", "no-view access", csr_rdata, '0);

        // R5: zero-mask clear does not dirty a clean context.
        step(1'b0, 2'd0, 2'd0, '0, 1'b0, 5'd0, 1'b0, 1'b1, 2'd2, 3'd0);
        step(1'b1, 2'd2, 2'd3, 64'hFF00, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 3'd0);
        check("R5", "zero mask leaves status clean", XLEN'(fs), XLEN'(2'd2));
        // R12: a read keeps status clean.
        step(1'b1, 2'd0, 2'd0, '1, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 3'd0);
        check("R12", "read leaves status clean", XLEN'(fs), XLEN'(2'd2));

        // R6/R7: report invalid+inexact, then clear all flags while overflow reports.
        step(1'b0, 2'd0, 2'd0, '0, 1'b1, 5'b10001, 1'b0, 1'b0, 2'd0, 3'd0);
        step(1'b1, 2'd2, 2'd3, 64'h1F, 1'b1, 5'b00100, 1'b0, 1'b0, 2'd0, 3'd0);
        step(1'b1, 2'd2, 2'd0, '0, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 3'd0);
        check("R7", "clear merged with report", csr_rdata, XLEN'(5'b00100));

        // R9: stored reserved mode 101 via whole word, then dynamic select.
        step(1'b1, 2'd0, 2'd1, 64'hA0, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 3'd7);
        step(1'b0, 2'd0, 2'd0, '0, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 3'd7);
        check("R9", "dynamic reserved illegal", XLEN'(rm_illegal), XLEN'(1'b1));
        // R8: static reserved code 110.
        step(1'b0, 2'd0, 2'd0, '0, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 3'd6);

        // R11: status load competes with a register write: dirty wins.
        step(1'b0, 2'd0, 2'd0, '0, 1'b0, 5'd0, 1'b0, 1'b1, 2'd0, 3'd0);
        step(1'b0, 2'd0, 2'd0, '0, 1'b0, 5'd0, 1'b1, 1'b1, 2'd1, 3'd0);
        check("R11", "dirty beats load", XLEN'(fs), XLEN'(2'd3));

        // Random phase.
        for (int i = 0; i < 4000; i++) begin
            logic [XLEN-1:0] src;
            logic [1:0] view, op;
            src  = {$urandom, $urandom};
            view = 2'($urandom);
            op   = 2'($urandom);
            if (($urandom & 3) == 0) src[7:0] = 8'd0;
            step(($urandom & 3) != 0, view, op, src,
                 ($urandom % 3) == 0, 5'($urandom), ($urandom & 3) == 0,
                 ($urandom & 15) == 0, 2'($urandom), 3'($urandom));
        end
        idle();

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule